// File: doc/BRIEF.md
# SM3 Message Expansion Engine

This block turns one 512-bit message block of the SM3 hash into the sequence of 68 expanded words, W0 through W67. It sends one word per handshake on a valid/ready output port. The block is loaded in a single cycle by a start pulse. The first sixteen words pass through unchanged. Each later word comes from a fixed recurrence over a window of the sixteen most recent words, built around the permutation P1(X) = X ^ (X <<< 15) ^ (X <<< 23). Here <<< is a circular left rotation of a 32-bit word and ^ is a bitwise XOR.

The window sits in registers and moves forward by one word each time the consumer takes a word. Each word therefore costs exactly one accepted handshake, whatever the data. While the consumer holds ready low, the port holds its word and index. A done strobe marks the transfer of the last word. The unit then goes idle and waits for the next start.

Top module: `sm3_msg_expander`

## Requirements
- R1: For j from 16 to 67 the word at index j equals P1(W[j-16] ^ W[j-9] ^ (W[j-3] <<< 15)) ^ (W[j-13] <<< 7) ^ W[j-6], where P1(X) = X ^ (X <<< 15) ^ (X <<< 23) on 32-bit words.
- R2: Indices 0 to 15 carry the input words unchanged and in index order, where word k is taken from block_i bits [32k+31:32k].
- R3: Each block yields exactly 68 words, and out_idx_o gives the index (0 to 67) of the word on out_word_o.
- R4: A start pulse while the unit is idle loads block_i; in the following cycle out_valid_o is high with index 0.
- R5: While out_valid_o is high and out_ready_i is low, out_word_o and out_idx_o hold their values and the window does not advance.
- R6: done_o is high exactly in the cycle in which the word with index 67 is accepted (valid and ready both high). out_valid_o is low in the cycle after that.
- R7: A start pulse while out_valid_o is high is ignored, and this includes the cycle of the final accept. The stream goes on unchanged, and the unit is idle after the last word.
- R8: With out_ready_i held high, the 68 words take exactly 68 consecutive cycles, for any data.
- R9: During reset and after it, out_valid_o and done_o are low until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an expansion when the unit is idle |
| block_i | input | 512 | Message block, word k in bits [32k+31:32k] |
| out_ready_i | input | 1 | Consumer accepts the presented word |
| out_valid_o | output | 1 | A word is presented |
| out_word_o | output | 32 | Presented expanded word |
| out_idx_o | output | 7 | Index of the presented word |
| done_o | output | 1 | High while the last word is accepted |

## Verification
Two events can fall in the same cycle: the accept of the final word and a new start pulse. The bench drives start high, with different block data, in the very cycle that word 67 is accepted, and also at scattered cycles in the middle of a stream. It judges the result by checking that done_o strobes once and that out_valid_o is low in the next cycle. It also checks that every word of the running stream still matches the arithmetic reference, and that a later start from idle begins cleanly at index 0. This is repeated under steady, alternating and bursty ready patterns over several data blocks.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned WIN     = 16;
  localparam int unsigned TOTAL   = 68;
  localparam int unsigned IDX_W   = $clog2(TOTAL);
  localparam int unsigned BLOCK_W = WORD_W * WIN;

  // window taps for the word being produced at index j = base + WIN
  localparam int unsigned TAP_M16 = WIN - 16;
  localparam int unsigned TAP_M13 = WIN - 13;
  localparam int unsigned TAP_M9  = WIN - 9;
  localparam int unsigned TAP_M6  = WIN - 6;
  localparam int unsigned TAP_M3  = WIN - 3;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    word_t r;
    r = (x << n) | (x >> (WORD_W - n));
    return r;
  endfunction

  function automatic word_t perm_p1(input word_t x);
    return x ^ rotl(x, 15) ^ rotl(x, 23);
  endfunction
endpackage

// File: rtl/sm3x_recur.sv
module sm3x_recur
  import sm3x_pkg::*;
(
  input  word_t [WIN-1:0] win_i,
  output word_t           next_o
);
  word_t mix;

  always_comb begin
    mix    = win_i[TAP_M16] ^ win_i[TAP_M9] ^ rotl(win_i[TAP_M3], 15);
    next_o = perm_p1(mix) ^ rotl(win_i[TAP_M13], 7) ^ win_i[TAP_M6];
  end
endmodule

// File: rtl/sm3x_window.sv
module sm3x_window
  import sm3x_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            adv_i,
  input  word_t [WIN-1:0] blk_i,
  input  word_t           new_i,
  output word_t [WIN-1:0] win_o
);
  word_t [WIN-1:0] win_q;
  word_t [WIN-1:0] win_d;
  logic            win_en;

  assign win_en = load_i | adv_i;

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    if (g == WIN - 1) begin : g_tail
      always_comb win_d[g] = load_i ? blk_i[g] : new_i;
    end else begin : g_body
      always_comb win_d[g] = load_i ? blk_i[g] : win_q[g+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign win_o = win_q;

  // R5
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && !adv_i |=> $stable(win_q));
  // R2
  window_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !load_i |=> win_q[0] == $past(win_q[1]));
endmodule

// File: rtl/sm3x_ctrl.sv
module sm3x_ctrl
  import sm3x_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  logic             valid_q, valid_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             accept, last, state_en;

  always_comb begin
    accept   = valid_q & ready_i;
    last     = (idx_q == LAST_IDX);
    load_o   = start_i & ~valid_q;
    adv_o    = accept;
    done_o   = accept & last;
    state_en = load_o | accept;
    valid_d  = valid_q;
    idx_d    = idx_q;
    if (load_o) begin
      valid_d = 1'b1;
      idx_d   = '0;
    end else if (accept) begin
      if (last) valid_d = 1'b0;
      else      idx_d   = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !valid_q |=> valid_q && idx_q == '0);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !ready_i |=> valid_q && $stable(idx_q));
  // R7
  busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && ready_i && !last |=> valid_q && idx_q == $past(idx_q) + 1'b1);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !valid_q);
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> idx_q <= LAST_IDX);
endmodule

// File: rtl/sm3_msg_expander.sv
module sm3_msg_expander
  import sm3x_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [BLOCK_W-1:0]  block_i,
  input  logic                out_ready_i,
  output logic                out_valid_o,
  output logic [WORD_W-1:0]   out_word_o,
  output logic [IDX_W-1:0]    out_idx_o,
  output logic                done_o
);
  word_t [WIN-1:0] blk_words;
  word_t [WIN-1:0] win;
  word_t           next_word;
  logic            load, adv;

  for (genvar k = 0; k < WIN; k++) begin : g_unpack
    assign blk_words[k] = block_i[k*WORD_W +: WORD_W];
  end

  sm3x_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .idx_o   (out_idx_o),
    .load_o  (load),
    .adv_o   (adv),
    .done_o  (done_o)
  );

  sm3x_recur u_recur (
    .win_i  (win),
    .next_o (next_word)
  );

  sm3x_window u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .adv_i  (adv),
    .blk_i  (blk_words),
    .new_i  (next_word),
    .win_o  (win)
  );

  assign out_word_o = win[0];

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> !done_o);
  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> $stable(out_word_o));
endmodule

// File: tb/sm3_msg_expander_tb.sv
module sm3_msg_expander_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [511:0] block_i;
  logic         out_ready_i;
  logic         out_valid_o;
  logic [31:0]  out_word_o;
  logic [6:0]   out_idx_o;
  logic         done_o;

  int nchk  = 0;
  int nfail = 0;
  bit finished = 0;
  logic [31:0] exp_w [68];

  always #4 clk = ~clk;

  sm3_msg_expander u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i),
    .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
    .out_word_o(out_word_o), .out_idx_o(out_idx_o), .done_o(done_o)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic build_ref(input logic [511:0] b);
    logic [31:0] t;
    for (int k = 0; k < 16; k++) exp_w[k] = b[32*k +: 32];
    for (int j = 16; j < 68; j++) begin
      t = exp_w[j-16] ^ exp_w[j-9] ^ rl(exp_w[j-3], 15);
      t = t ^ rl(t, 15) ^ rl(t, 23);
      exp_w[j] = t ^ rl(exp_w[j-13], 7) ^ exp_w[j-6];
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // mode 0: ready high; 1: alternating; 2: bursty stalls
  task automatic run_block(input logic [511:0] b, input int mode, input bit inject);
    int got;
    int cyc;
    bit r;
    build_ref(b);
    @(negedge clk);
    block_i = b; start_i = 1'b1; out_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(out_valid_o == 1'b1, "R4 valid", 64'(out_valid_o), 64'd1);
    chk(out_idx_o == 7'd0, "R4 idx", 64'(out_idx_o), 64'd0);
    got = 0; cyc = 0;
    while (got < 68 && cyc < 2000) begin
      case (mode)
        0: r = 1'b1;
        1: r = cyc[0];
        default: r = ((cyc % 7) < 3) || ((cyc % 11) == 5);
      endcase
      out_ready_i = r;
      if (inject && (((cyc % 9) == 4) || got == 67)) begin
        start_i = 1'b1; block_i = ~b;
      end else begin
        start_i = 1'b0;
      end
      #1;
      chk(out_valid_o == 1'b1, "R3 valid", 64'(out_valid_o), 64'd1);
      chk(out_idx_o == 7'(got), "R3 idx", 64'(out_idx_o), 64'(got));
      if (got < 16)
        chk(out_word_o == exp_w[got], "R2 word", 64'(out_word_o), 64'(exp_w[got]));
      else
        chk(out_word_o == exp_w[got], "R1 word", 64'(out_word_o), 64'(exp_w[got]));
      chk(done_o == (r && got == 67), "R6 done", 64'(done_o), 64'(r && got == 67));
      if (r) got++;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0; out_ready_i = 1'b0;
    #1;
    chk(out_valid_o == 1'b0, inject ? "R7 idle after final" : "R6 idle",
        64'(out_valid_o), 64'd0);
    chk(done_o == 1'b0, "R6 done low", 64'(done_o), 64'd0);
    if (mode == 0)
      chk(cyc == 68, "R8 cycles", 64'(cyc), 64'd68);
    if (mode != 0)
      chk(cyc > 68, "R5 stalls seen", 64'(cyc), 64'd69);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [511:0] b;
    logic [31:0]  s;
    rst_n = 1'b0; start_i = 1'b0; block_i = '0; out_ready_i = 1'b0;
    #20;
    chk(out_valid_o == 1'b0, "R9 valid in reset", 64'(out_valid_o), 64'd0);
    chk(done_o == 1'b0, "R9 done in reset", 64'(done_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid_o == 1'b0, "R9 valid after reset", 64'(out_valid_o), 64'd0);

    run_block('0, 0, 1'b0);
    run_block({512{1'b1}}, 0, 1'b0);
    b = '0;
    for (int k = 0; k < 16; k++) b[32*k +: 32] = 32'(k + 1);
    run_block(b, 1, 1'b0);
    b = '0; b[31:0] = 32'h61626380; b[511:480] = 32'h00000018;
    run_block(b, 0, 1'b1);
    s = 32'h1234_5677;
    for (int n = 0; n < 9; n++) begin
      for (int k = 0; k < 16; k++) begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        b[32*k +: 32] = s;
      end
      run_block(b, n % 3, n[0]);
    end
    // single-bit walk through the window
    for (int k = 0; k < 16; k += 5) begin
      b = '0; b[32*k + k] = 1'b1;
      run_block(b, 0, 1'b1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule